// File: doc/BRIEF.md
# Tape Record Word Transfer Engine

This engine sits between a host data channel that moves 16-bit words and a byte-organised record buffer inside a tape controller. The host issues a command. On a read, the engine presents the buffered record to the host as 16-bit words, one word per transfer interval, and raises a data-ready flag for each word. On a write, it gathers host words into the buffer as byte pairs for as long as the host keeps its transfer-enable input high. Then it reports the record length. Each record ends with an inter-record gap delay. A one-cycle done pulse follows the gap.

The engine runs as a single state machine with five states:
- `ST_IDLE` waits for a command.
- `ST_RD_SVC` serves read slots.
- `ST_WR_LEAD` is the empty first write slot.
- `ST_WR_SVC` serves the write slots that store data.
- `ST_GAP` times the gap.

The transitions are:
- idle-to-read and idle-to-write, when a command is accepted.
- read-to-gap, when the record is exhausted or is a file mark.
- lead-to-store, when the host still requests transfer.
- lead-to-gap and store-to-gap, when the host withdraws its request.
- gap-to-read (re-arm), for a diagnostic read.
- gap-to-idle, which pulses done.

A slot timer and a word-organised buffer support the state machine.

Top module: `tape_word_xfer`

## Requirements
- R1: After reset the block is idle. Busy, done, data-ready and all four status bits are 0, and the reported length is 0.
- R2: A word carries two record bytes. The earlier byte is in bits 15:8 and the later byte in bits 7:0. On a read of odd length, the last word has its low byte forced to 0.
- R3: A command is taken when go is high in idle. `cmd_op_i[1]`=1 selects write. Otherwise the command is a read, and `cmd_op_i[0]`=1 makes it diagnostic. The first read slot falls XFER_CYC cycles after the accepting edge, and one word follows every XFER_CYC cycles while bytes remain. Data-ready is set at each word and cleared by a host acknowledge. A slot that sets the flag wins over an acknowledge in the same cycle.
- R4: If data-ready is still set when a read slot presents the next word, both timing error and parity error are set. Within a command, parity stays set once set.
- R5: A GAP_CYC-cycle gap starts at the slot that ends a record. When it expires, done is high for exactly one cycle, and busy is low in that cycle.
- R6: At the end of a record, the odd bit equals bit 0 of the record's byte count, and the reported length equals that count.
- R7: A read whose mark input was high when it was sampled delivers no words. It sets end-of-file and odd, reports length 0, and then runs the gap.
- R8: After each gap, a diagnostic read samples the length and mark inputs again and reads the next record. It finishes only after a file-mark record.
- R9: The first write slot stores nothing and resets the byte pointer. Each later slot stores the host word present at that slot as two bytes. Data-ready is raised at every slot after which transfer continues.
- R10: A write word that would overflow the BUF_BYTES buffer is dropped and sets parity error. The reported length stays at BUF_BYTES.
- R11: At the first slot that sees transfer-enable low, the write commits the stored byte count (0 if none) as the length, and the gap follows.
- R12: A read length above BUF_BYTES is limited to BUF_BYTES and sets parity error.
- R13: A go pulse that arrives while busy is ignored.
- R14: An accepted command clears all four status bits, data-ready and the reported length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Bit 1: write; bit 0: diagnostic read |
| rec_len_i | input | LEN_W | Byte count of the record to read |
| rec_mark_i | input | 1 | The record to read is a file mark |
| xfer_en_i | input | 1 | Host transfer request during writes |
| host_wdata_i | input | 16 | Host write word |
| host_ack_i | input | 1 | Host has taken or supplied a word |
| host_rdata_o | output | 16 | Read word to the host |
| data_flag_o | output | 1 | Data-ready flag |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion pulse |
| rec_len_o | output | LEN_W | Reported record length |
| stat_odd_o | output | 1 | Odd byte count |
| stat_par_o | output | 1 | Parity / data error |
| stat_tim_o | output | 1 | Timing overrun |
| stat_eof_o | output | 1 | File mark seen |

## Verification
The bench builds the engine with BUF_BYTES=8, XFER_CYC=3 and GAP_CYC=5. An 8-byte buffer fills after four words, so the overflow drop is reached within a single short write. A 4-bit length port can then carry a value of 12, which exercises the length limit. A 3-cycle slot gives a host that does not acknowledge a timing overrun on the second word. A 5-cycle gap keeps each record, and each re-armed diagnostic record, within a few dozen cycles.

// File: rtl/tape_xfer_pkg.sv
`timescale 1ns/1ps
package tape_xfer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SVC,
        ST_WR_LEAD,
        ST_WR_SVC,
        ST_GAP
    } xfer_state_e;
endpackage

// File: rtl/tape_slot_timer.sv
`timescale 1ns/1ps
// Down-counter that expires when it reaches zero; reloaded at each slot.
module tape_slot_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/tape_word_buf.sv
`timescale 1ns/1ps
// Record buffer held as byte pairs: bits 15:8 the earlier byte.
module tape_word_buf #(
    parameter int WORDS = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [15:0]   wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [15:0]   rdata_o
);
    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/tape_word_xfer.sv
`timescale 1ns/1ps
module tape_word_xfer
    import tape_xfer_pkg::*;
#(
    parameter  int BUF_BYTES = 256,
    parameter  int XFER_CYC  = 15,
    parameter  int GAP_CYC   = 100,
    localparam int LEN_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_go_i,
    input  logic [1:0]       cmd_op_i,
    input  logic [LEN_W-1:0] rec_len_i,
    input  logic             rec_mark_i,
    input  logic             xfer_en_i,
    input  logic [15:0]      host_wdata_i,
    input  logic             host_ack_i,
    output logic [15:0]      host_rdata_o,
    output logic             data_flag_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [LEN_W-1:0] rec_len_o,
    output logic             stat_odd_o,
    output logic             stat_par_o,
    output logic             stat_tim_o,
    output logic             stat_eof_o
);
    localparam int WORDS = BUF_BYTES / 2;
    localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int TMAX  = (XFER_CYC > GAP_CYC) ? XFER_CYC : GAP_CYC;
    localparam int TW    = $clog2(TMAX + 1);
    localparam logic [TW-1:0]    XFER_LD = TW'(XFER_CYC - 1);
    localparam logic [TW-1:0]    GAP_LD  = TW'(GAP_CYC - 1);
    localparam logic [LEN_W:0]   BUF_LIM = (LEN_W + 1)'(BUF_BYTES);
    localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_BYTES);

    xfer_state_e state_q, state_n;

    logic [LEN_W-1:0] ptr_q, ptr_n, len_q, len_n, reclen_q, reclen_n;
    logic             mark_q, mark_n, diag_q, diag_n;
    logic             flag_q, flag_n, done_q, done_n;
    logic             odd_q, odd_n, par_q, par_n, tim_q, tim_n, eof_q, eof_n;
    logic [15:0]      rdata_q, rdata_n;

    logic             tmr_load, tick;
    logic [TW-1:0]    tmr_val;
    logic             buf_we;
    logic [15:0]      buf_rdata;

    logic [LEN_W:0]   ptr_ext, ptr1, ptr2, len_ext;
    logic             in_over, wr_room;
    logic [LEN_W-1:0] in_len, wr_ptr;
    logic [7:0]       rd_lo;

    tape_slot_timer #(.CNT_W(TW)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tick)
    );

    tape_word_buf #(.WORDS(WORDS), .AW(AW)) i_buf (
        .clk     (clk),
        .we_i    (buf_we),
        .waddr_i (ptr_q[AW:1]),
        .wdata_i (host_wdata_i),
        .raddr_i (ptr_q[AW:1]),
        .rdata_o (buf_rdata)
    );

    assign ptr_ext = {1'b0, ptr_q};
    assign ptr1    = ptr_ext + 1'b1;
    assign ptr2    = ptr_ext + 2'd2;
    assign len_ext = {1'b0, len_q};
    assign in_over = ({1'b0, rec_len_i} > BUF_LIM);
    assign in_len  = in_over ? BUF_LEN : rec_len_i;
    assign wr_room = (ptr2 <= BUF_LIM);
    assign wr_ptr  = wr_room ? ptr2[LEN_W-1:0] : ptr_q;
    assign rd_lo   = (ptr1 < len_ext) ? buf_rdata[7:0] : 8'h00;

    // Next-state and datapath decisions.
    always_comb begin
        state_n  = state_q;
        ptr_n    = ptr_q;
        len_n    = len_q;
        mark_n   = mark_q;
        diag_n   = diag_q;
        flag_n   = flag_q & ~host_ack_i;
        rdata_n  = rdata_q;
        odd_n    = odd_q;
        par_n    = par_q;
        tim_n    = tim_q;
        eof_n    = eof_q;
        reclen_n = reclen_q;
        done_n   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = XFER_LD;
        buf_we   = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (cmd_go_i) begin
                    ptr_n    = '0;
                    len_n    = in_len;
                    mark_n   = rec_mark_i;
                    diag_n   = cmd_op_i[0] & ~cmd_op_i[1];
                    flag_n   = 1'b0;
                    odd_n    = 1'b0;
                    par_n    = in_over & ~cmd_op_i[1];
                    tim_n    = 1'b0;
                    eof_n    = 1'b0;
                    reclen_n = '0;
                    tmr_load = 1'b1;
                    state_n  = cmd_op_i[1] ? ST_WR_LEAD : ST_RD_SVC;
                end
            end
            ST_RD_SVC: begin
                if (tick) begin
                    tmr_load = 1'b1;
                    if (mark_q) begin
                        eof_n    = 1'b1;
                        odd_n    = 1'b1;
                        reclen_n = '0;
                        tmr_val  = GAP_LD;
                        state_n  = ST_GAP;
                    end else if (ptr_ext < len_ext) begin
                        if (flag_q) begin
                            tim_n = 1'b1;
                            par_n = 1'b1;
                        end
                        rdata_n = {buf_rdata[15:8], rd_lo};
                        ptr_n   = ptr2[LEN_W-1:0];
                        flag_n  = 1'b1;
                    end else begin
                        odd_n    = len_q[0];
                        reclen_n = len_q;
                        tmr_val  = GAP_LD;
                        state_n  = ST_GAP;
                    end
                end
            end
            ST_WR_LEAD: begin
                if (tick) begin
                    tmr_load = 1'b1;
                    ptr_n    = '0;
                    if (xfer_en_i) begin
                        flag_n  = 1'b1;
                        state_n = ST_WR_SVC;
                    end else begin
                        reclen_n = '0;
                        odd_n    = 1'b0;
                        tmr_val  = GAP_LD;
                        state_n  = ST_GAP;
                    end
                end
            end
            ST_WR_SVC: begin
                if (tick) begin
                    tmr_load = 1'b1;
                    buf_we   = wr_room;
                    ptr_n    = wr_ptr;
                    if (!wr_room) par_n = 1'b1;
                    if (xfer_en_i) begin
                        flag_n = 1'b1;
                    end else begin
                        reclen_n = wr_ptr;
                        odd_n    = wr_ptr[0];
                        tmr_val  = GAP_LD;
                        state_n  = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (diag_q && !mark_q) begin
                        ptr_n    = '0;
                        len_n    = in_len;
                        mark_n   = rec_mark_i;
                        par_n    = par_q | in_over;
                        tmr_load = 1'b1;
                        state_n  = ST_RD_SVC;
                    end else begin
                        done_n  = 1'b1;
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Datapath and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            len_q    <= '0;
            mark_q   <= 1'b0;
            diag_q   <= 1'b0;
            flag_q   <= 1'b0;
            rdata_q  <= '0;
            odd_q    <= 1'b0;
            par_q    <= 1'b0;
            tim_q    <= 1'b0;
            eof_q    <= 1'b0;
            reclen_q <= '0;
            done_q   <= 1'b0;
        end else begin
            ptr_q    <= ptr_n;
            len_q    <= len_n;
            mark_q   <= mark_n;
            diag_q   <= diag_n;
            flag_q   <= flag_n;
            rdata_q  <= rdata_n;
            odd_q    <= odd_n;
            par_q    <= par_n;
            tim_q    <= tim_n;
            eof_q    <= eof_n;
            reclen_q <= reclen_n;
            done_q   <= done_n;
        end
    end

    assign host_rdata_o = rdata_q;
    assign data_flag_o  = flag_q;
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;
    assign rec_len_o    = reclen_q;
    assign stat_odd_o   = odd_q;
    assign stat_par_o   = par_q;
    assign stat_tim_o   = tim_q;
    assign stat_eof_o   = eof_q;
endmodule

// File: rtl/tape_word_xfer_chk.sv
`timescale 1ns/1ps
module tape_word_xfer_chk #(
    parameter int BUF_BYTES = 256,
    parameter int LEN_W     = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic             data_flag_o,
    input logic             stat_odd_o,
    input logic             stat_par_o,
    input logic             stat_tim_o,
    input logic             stat_eof_o,
    input logic [LEN_W-1:0] rec_len_o
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                   // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                   // R5
    AST_FLAG_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_flag_o) |-> busy_o);                        // R3
    AST_TIM_WITH_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        stat_tim_o |-> stat_par_o);                            // R4
    AST_PAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && stat_par_o) |=> stat_par_o);                // R4
    AST_EOF_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_eof_o |-> stat_odd_o);                            // R7
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rec_len_o <= LEN_W'(BUF_BYTES));                       // R10
endmodule

bind tape_word_xfer tape_word_xfer_chk #(
    .BUF_BYTES (BUF_BYTES),
    .LEN_W     (LEN_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .data_flag_o (data_flag_o),
    .stat_odd_o  (stat_odd_o),
    .stat_par_o  (stat_par_o),
    .stat_tim_o  (stat_tim_o),
    .stat_eof_o  (stat_eof_o),
    .rec_len_o   (rec_len_o)
);

// File: tb/test_tape_word_xfer.sv
`timescale 1ns/1ps
module test_tape_word_xfer;
    localparam int BUF   = 8;
    localparam int XFER  = 3;
    localparam int GAP   = 5;
    localparam int LW    = $clog2(BUF + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_go = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [LW-1:0] rec_len = '0;
    logic rec_mark = 1'b0;
    logic xfer_en = 1'b0;
    logic [15:0] host_wdata = '0;
    logic host_ack = 1'b0;
    logic [15:0] host_rdata;
    logic data_flag, busy, done, odd, par, tim, eof;
    logic [LW-1:0] rlen;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int ndone  = 0;
    bit auto_ack = 1'b0;
    logic [15:0] wq[$];
    logic [15:0] got[$];

    always #2.5 clk = ~clk;

    tape_word_xfer #(.BUF_BYTES(BUF), .XFER_CYC(XFER), .GAP_CYC(GAP)) i_tape_word_xfer (
        .clk(clk), .rst_n(rst_n), .cmd_go_i(cmd_go), .cmd_op_i(cmd_op),
        .rec_len_i(rec_len), .rec_mark_i(rec_mark), .xfer_en_i(xfer_en),
        .host_wdata_i(host_wdata), .host_ack_i(host_ack),
        .host_rdata_o(host_rdata), .data_flag_o(data_flag), .busy_o(busy),
        .done_o(done), .rec_len_o(rlen), .stat_odd_o(odd), .stat_par_o(par),
        .stat_tim_o(tim), .stat_eof_o(eof)
    );

    task automatic cmp(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
        end
    endtask

    // Behavioural reference: byte array, countdown, per-edge update.
    logic [7:0] mb [BUF];
    int ms, mcnt, mptr, mlen, mrl;
    bit mmark, mdiag, mflag, modd, mpar, mtim, meof, mdone;
    int mrd;

    always @(posedge clk) begin
        int ilen;
        bit iover, oflag;
        if (!rst_n) begin
            ms = 0; mcnt = 0; mptr = 0; mlen = 0; mrl = 0; mrd = 0;
            mmark = 0; mdiag = 0; mflag = 0; modd = 0; mpar = 0; mtim = 0; meof = 0; mdone = 0;
        end else begin
            oflag = mflag;
            mdone = 0;
            if (host_ack) mflag = 0;
            ilen  = int'(rec_len);
            iover = (ilen > BUF);
            if (iover) ilen = BUF;
            if (ms != 0 && mcnt > 0) mcnt--;
            case (ms)
                0: if (cmd_go) begin
                    mptr = 0; mlen = ilen; mmark = rec_mark;
                    mdiag = cmd_op[0] && !cmd_op[1];
                    mflag = 0; modd = 0; mtim = 0; meof = 0; mrl = 0;
                    mpar = iover && !cmd_op[1];
                    mcnt = XFER; ms = cmd_op[1] ? 2 : 1;
                end
                1: if (mcnt == 0) begin
                    mcnt = XFER;
                    if (mmark) begin
                        meof = 1; modd = 1; mrl = 0; ms = 4; mcnt = GAP;
                    end else if (mptr < mlen) begin
                        if (oflag) begin mtim = 1; mpar = 1; end
                        mrd = (int'(mb[mptr]) << 8) | ((mptr + 1 < mlen) ? int'(mb[mptr+1]) : 0);
                        mptr += 2; mflag = 1;
                    end else begin
                        modd = mlen[0]; mrl = mlen; ms = 4; mcnt = GAP;
                    end
                end
                2: if (mcnt == 0) begin
                    mptr = 0;
                    if (xfer_en) begin mflag = 1; mcnt = XFER; ms = 3; end
                    else begin mrl = 0; modd = 0; ms = 4; mcnt = GAP; end
                end
                3: if (mcnt == 0) begin
                    if (mptr + 2 <= BUF) begin
                        mb[mptr] = host_wdata[15:8]; mb[mptr+1] = host_wdata[7:0]; mptr += 2;
                    end else mpar = 1;
                    if (xfer_en) begin mflag = 1; mcnt = XFER; end
                    else begin mrl = mptr; modd = mptr[0]; ms = 4; mcnt = GAP; end
                end
                4: if (mcnt == 0) begin
                    if (mdiag && !mmark) begin
                        mptr = 0; mlen = ilen; mmark = rec_mark; mpar = mpar | iover;
                        mcnt = XFER; ms = 1;
                    end else begin
                        mdone = 1; ms = 0;
                    end
                end
                default: ms = 0;
            endcase
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            cmp("R5 R13", "busy", busy, ms != 0);
            cmp("R5", "done", done, mdone);
            cmp("R3 R9", "data_flag", data_flag, mflag);
            cmp("R2", "rdata", host_rdata, mrd);
            cmp("R6", "odd", odd, modd);
            cmp("R4 R10 R12", "parity", par, mpar);
            cmp("R4", "timing", tim, mtim);
            cmp("R7", "eof", eof, meof);
            cmp("R6 R11", "rec_len", rlen, mrl);
            if (done) ndone++;
        end
    end

    // Host side of the data channel.
    always @(negedge clk) begin
        host_ack = 1'b0;
        if (rst_n && auto_ack && data_flag) begin
            host_ack = 1'b1;
            got.push_back(host_rdata);
            if (wq.size() > 0) begin
                host_wdata = wq.pop_front();
                if (wq.size() == 0) xfer_en = 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic run(input logic [1:0] op, input int len, input bit mark);
        @(negedge clk);
        cmd_op = op; rec_len = LW'(len); rec_mark = mark; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cmp("R1", "busy", busy, 0);
        cmp("R1", "flag", data_flag, 0);
        cmp("R1", "status", {odd, par, tim, eof}, 0);
        cmp("R1", "rec_len", rlen, 0);

        // R9 R11: write three words
        auto_ack = 1; wq = '{16'hA1B2, 16'hC3D4, 16'hE5F6}; xfer_en = 1;
        n0 = ndone;
        run(2'b10, 0, 0);
        cmp("R11", "write length", rlen, 6);
        cmp("R6", "write odd", odd, 0);
        cmp("R5", "one done", ndone - n0, 1);

        // R2 R3: read back, even length
        got.delete();
        run(2'b00, 6, 0);
        cmp("R3", "word count", got.size(), 3);
        if (got.size() == 3) begin
            cmp("R2", "w0", got[0], 16'hA1B2);
            cmp("R2", "w2", got[2], 16'hE5F6);
        end

        // R2 R6: odd length
        got.delete();
        run(2'b00, 5, 0);
        cmp("R6", "odd set", odd, 1);
        cmp("R6", "len 5", rlen, 5);
        if (got.size() == 3) cmp("R2", "pad byte", got[2], 16'hE500);
        else cmp("R3", "odd word count", got.size(), 3);

        // R4: host does not take words
        auto_ack = 0;
        run(2'b00, 6, 0);
        cmp("R4", "timing", tim, 1);
        cmp("R4", "parity", par, 1);
        auto_ack = 1;
        @(negedge clk);

        // R14: clean read clears status
        run(2'b00, 4, 0);
        cmp("R14", "timing cleared", tim, 0);
        cmp("R14", "parity cleared", par, 0);

        // R7: file mark
        got.delete();
        run(2'b00, 4, 1);
        cmp("R7", "eof", eof, 1);
        cmp("R7", "odd", odd, 1);
        cmp("R7", "no words", got.size(), 0);

        // R8: diagnostic read continues until a file mark
        got.delete();
        @(negedge clk);
        cmd_op = 2'b01; rec_len = LW'(4); rec_mark = 0; cmd_go = 1;
        @(negedge clk);
        cmd_go = 0; rec_mark = 1;
        while (!done) @(negedge clk);
        @(negedge clk);
        cmp("R8", "diag words", got.size(), 2);
        cmp("R8", "diag eof", eof, 1);

        // R10: overflow write
        wq = '{16'h1122, 16'h3344, 16'h5566, 16'h7788, 16'h99AA, 16'hBBCC}; xfer_en = 1;
        run(2'b10, 0, 0);
        cmp("R10", "full length", rlen, BUF);
        cmp("R10", "parity", par, 1);
        got.delete();
        run(2'b00, 8, 0);
        if (got.size() == 4) cmp("R10", "last kept", got[3], 16'h7788);
        else cmp("R10", "read count", got.size(), 4);

        // R11: write with no transfer request
        xfer_en = 0; wq.delete();
        run(2'b10, 0, 0);
        cmp("R11", "empty write", rlen, 0);

        // R12: over-long read length
        run(2'b00, 12, 0);
        cmp("R12", "limited length", rlen, BUF);
        cmp("R12", "parity", par, 1);

        // R13: go while busy is ignored
        @(negedge clk);
        cmd_op = 2'b00; rec_len = LW'(4); rec_mark = 0; cmd_go = 1;
        @(negedge clk);
        cmd_go = 0;
        repeat (2) @(negedge clk);
        cmd_op = 2'b10; cmd_go = 1;
        @(negedge clk);
        cmd_go = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        cmp("R13", "length unchanged", rlen, 4);
        repeat (3) @(negedge clk);
        cmp("R13", "stays idle", busy, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule